// File: doc/BRIEF.md
# Pulse Width Timer with Phase Timeouts

This block measures how long an asynchronous input pin stays at a chosen logic level, counting in microsecond ticks supplied by a shared tick enable. A measurement begins with a one-cycle start strobe that carries the level of interest and a timeout value. If the pin is not yet at that level, the block first waits for it to arrive. It then counts ticks for as long as the pin holds the level. The block reports either the measured width or a negative code that says which phase ran out of time.

The pin goes through a two-flop synchronizer before any comparison is made. One timeout value guards the waiting phase and the counting phase, and each phase gets its own full allowance. Completion is signalled by a single-cycle done pulse. The signed 32-bit result stays on the output until the next completion.

Top module: `pulse_span_timer`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is 0.
- R2: `level_sel_i` captured at an accepted start picks the level to time: 1 times a high pulse, 0 times a low pulse. Later changes on `level_sel_i` and `timeout_us_i` have no effect on a running measurement.
- R3: If the synchronized pin already equals the selected level when start is accepted, counting begins at once. The result is the number of tick cycles seen while the pin held the level.
- R4: If the pin differs from the selected level at start, the block waits for it. Ticks seen during the wait are not included in the reported width.
- R5: If the waiting phase sees as many ticks as the timeout value, the block finishes with result -2 (32'hFFFF_FFFE).
- R6: If the counting phase sees as many ticks as the timeout value while the pin still holds the level, the block finishes with result -1 (32'hFFFF_FFFF).
- R7: The timeout allowance restarts when counting begins, so a wait of timeout-1 ticks followed by a pulse of timeout-1 ticks succeeds with width timeout-1.
- R8: A successful result is never negative and is below the timeout (a timeout of 0 is treated as 1).
- R9: `done_o` is high for exactly one cycle per measurement, and `result_o` holds its value until the next `done_o`.
- R10: A start strobe that arrives while a measurement is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to begin a measurement |
| level_sel_i | input | 1 | Level to time: 1 = high pulse, 0 = low pulse |
| timeout_us_i | input | TMO_W | Timeout per phase, in ticks |
| pin_async_i | input | 1 | Asynchronous input being measured |
| tick_us_i | input | 1 | One-cycle microsecond tick enable |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Signed width in ticks, or -1 / -2 timeout code |

## Verification
The hardest cases to reach are the ones where both phases run. A wait that stops just short of its timeout has to be followed by a pulse that also stops just short of the timeout. Only then does the test show that the allowance restarts and that ticks from the wait do not leak into the width. The bench gets there by holding the pin at the opposite level for exactly timeout-1 ticks. It then lets the synchronizer settle with no ticks running, and counts off timeout-1 more ticks before releasing the pin. A second hard case is a start strobe that arrives during a measurement with a different level and timeout. It is issued in the middle of a counted pulse, and the check is that the width and the number of done pulses match the first request alone.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_MEAS = 2'd2
  } pst_state_e;

  localparam int RES_W = 32;
  localparam logic signed [RES_W-1:0] CODE_MEAS_TMO = -32'sd1;
  localparam logic signed [RES_W-1:0] CODE_WAIT_TMO = -32'sd2;
endpackage

// File: rtl/pst_sync.sv
module pst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pst_phase_cnt.sv
module pst_phase_cnt #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          expire
);
  logic [CW:0] count_inc;

  assign count_inc = {1'b0, count} + 1'b1;
  assign expire    = tick && (count_inc >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (tick)  count <= count_inc[CW-1:0];
  end
endmodule

// File: rtl/pst_ctrl.sv
module pst_ctrl
  import pst_pkg::*;
#(
  parameter int TMO_W = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    level_sel,
  input  logic [TMO_W-1:0]        timeout,
  input  logic                    pin_s,
  input  logic [TMO_W-1:0]        count,
  input  logic                    expire,
  output logic                    cnt_clr,
  output logic [TMO_W-1:0]        limit,
  output logic                    busy,
  output logic                    done,
  output logic signed [RES_W-1:0] result
);
  pst_state_e state;
  logic       lvl_q;
  logic       at_level;

  assign at_level = (pin_s == lvl_q);
  assign busy     = (state != ST_IDLE);
  assign cnt_clr  = (state == ST_IDLE) || ((state == ST_WAIT) && at_level);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      lvl_q  <= 1'b0;
      limit  <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            lvl_q <= level_sel;
            limit <= (timeout == '0) ? TMO_W'(1) : timeout;
            state <= (pin_s == level_sel) ? ST_MEAS : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (at_level) begin
            state <= ST_MEAS;
          end else if (expire) begin
            done   <= 1'b1;
            result <= CODE_WAIT_TMO;
            state  <= ST_IDLE;
          end
        end
        ST_MEAS: begin
          if (!at_level) begin
            done   <= 1'b1;
            result <= {{(RES_W-TMO_W){1'b0}}, count};
            state  <= ST_IDLE;
          end else if (expire) begin
            done   <= 1'b1;
            result <= CODE_MEAS_TMO;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pulse_span_timer.sv
module pulse_span_timer #(
  parameter int TMO_W     = 20,
  parameter int SYNC_STGS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic                    level_sel_i,
  input  logic [TMO_W-1:0]        timeout_us_i,
  input  logic                    pin_async_i,
  input  logic                    tick_us_i,
  output logic                    done_o,
  output logic signed [31:0]      result_o
);
  logic             pin_s;
  logic             cnt_clr;
  logic             expire;
  logic             busy_w;
  logic [TMO_W-1:0] count;
  logic [TMO_W-1:0] limit;

  pst_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_async_i),
    .dout (pin_s)
  );

  pst_phase_cnt #(.CW(TMO_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (cnt_clr),
    .tick   (tick_us_i),
    .limit  (limit),
    .count  (count),
    .expire (expire)
  );

  pst_ctrl #(.TMO_W(TMO_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start_i),
    .level_sel (level_sel_i),
    .timeout   (timeout_us_i),
    .pin_s     (pin_s),
    .count     (count),
    .expire    (expire),
    .cnt_clr   (cnt_clr),
    .limit     (limit),
    .busy      (busy_w),
    .done      (done_o),
    .result    (result_o)
  );
endmodule

// File: rtl/pst_checker.sv
module pst_checker #(
  parameter int TMO_W = 20
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic [TMO_W-1:0]   timeout_us_i,
  input logic               busy,
  input logic               done_o,
  input logic signed [31:0] result_o
);
  logic [TMO_W-1:0] tmo_q;

  always_ff @(posedge clk) begin
    if (rst) tmo_q <= TMO_W'(1);
    else if (start_i && !busy)
      tmo_q <= (timeout_us_i == '0) ? TMO_W'(1) : timeout_us_i;
  end

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));

  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(busy));

  assert_result_range_R8: assert property (@(posedge clk) disable iff (rst)
    (done_o && !result_o[31]) |-> (result_o < {{(32-TMO_W){1'b0}}, tmo_q}));

  assert_code_legal_R5_R6: assert property (@(posedge clk) disable iff (rst)
    (done_o && result_o[31]) |-> (result_o == -32'sd1 || result_o == -32'sd2));
endmodule

bind pulse_span_timer pst_checker #(.TMO_W(TMO_W)) u_pst_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .timeout_us_i (timeout_us_i),
  .busy         (busy_w),
  .done_o       (done_o),
  .result_o     (result_o)
);

// File: tb/pulse_span_timer_bench.sv
`timescale 1ns/1ps
module pulse_span_timer_bench;
  localparam int TMO_W = 20;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   start_i = 1'b0;
  logic                   level_sel_i = 1'b0;
  logic [TMO_W-1:0]       timeout_us_i = '0;
  logic                   pin_async_i = 1'b0;
  logic                   tick_us_i = 1'b0;
  logic                   done_o;
  logic signed [31:0]     result_o;

  int n_tests = 0;
  int n_fail  = 0;
  int done_cnt = 0;
  logic signed [31:0] last_res = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  pulse_span_timer #(.TMO_W(TMO_W)) u_pulse_span_timer (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .level_sel_i  (level_sel_i),
    .timeout_us_i (timeout_us_i),
    .pin_async_i  (pin_async_i),
    .tick_us_i    (tick_us_i),
    .done_o       (done_o),
    .result_o     (result_o)
  );

  always @(negedge clk) begin
    if (!rst && done_o) begin
      done_cnt <= done_cnt + 1;
      last_res <= result_o;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_us_i = 1'b1;
      @(negedge clk) tick_us_i = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic kick(input bit lvl, input int tmo);
    @(negedge clk);
    level_sel_i  = lvl;
    timeout_us_i = TMO_W'(tmo);
    start_i      = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // R3: pin already at level, width counted directly
  task automatic t_immediate(input bit lvl, input int n, input int tmo, input string req);
    int d0;
    pin_async_i = lvl; idle(5);
    d0 = done_cnt;
    kick(lvl, tmo);
    ticks(n);
    pin_async_i = ~lvl; idle(6);
    check(done_cnt == d0 + 1, req, done_cnt - d0, 1);
    check(last_res == n, req, last_res, n);
  endtask

  // R4 and R7: wait phase followed by counted pulse
  task automatic t_wait_then_measure();
    int d0;
    pin_async_i = 1'b0; idle(5);
    d0 = done_cnt;
    kick(1'b1, 6);
    ticks(5);
    pin_async_i = 1'b1; idle(5);
    ticks(5);
    pin_async_i = 1'b0; idle(6);
    check(done_cnt == d0 + 1, "R4 one done", done_cnt - d0, 1);
    check(last_res == 5, "R4/R7 width excludes wait", last_res, 5);
  endtask

  // R5: wait phase timeout
  task automatic t_wait_timeout();
    int d0;
    pin_async_i = 1'b1; idle(5);
    d0 = done_cnt;
    kick(1'b0, 4);
    ticks(3);
    check(done_cnt == d0, "R5 no early timeout", done_cnt - d0, 0);
    ticks(1);
    idle(2);
    check(done_cnt == d0 + 1, "R5 done count", done_cnt - d0, 1);
    check(last_res == -2, "R5 wait timeout code", last_res, -2);
  endtask

  // R6: counting phase timeout
  task automatic t_meas_timeout();
    int d0;
    pin_async_i = 1'b1; idle(5);
    d0 = done_cnt;
    kick(1'b1, 7);
    ticks(7);
    idle(2);
    check(done_cnt == d0 + 1, "R6 done count", done_cnt - d0, 1);
    check(last_res == -1, "R6 measure timeout code", last_res, -1);
    pin_async_i = 1'b0; idle(8);
    check(done_cnt == d0 + 1, "R6 no extra done", done_cnt - d0, 1);
  endtask

  // R8: zero timeout behaves as one
  task automatic t_zero_timeout();
    int d0;
    pin_async_i = 1'b0; idle(5);
    d0 = done_cnt;
    kick(1'b0, 0);
    idle(4);
    pin_async_i = 1'b1; idle(6);
    check(last_res == 0 && done_cnt == d0 + 1, "R8 zero-width success", last_res, 0);
  endtask

  // R10 and R2: start while busy ignored, inputs latched
  task automatic t_busy_start();
    int d0;
    pin_async_i = 1'b1; idle(5);
    d0 = done_cnt;
    kick(1'b1, 9);
    ticks(3);
    kick(1'b0, 1);
    level_sel_i = 1'b0; timeout_us_i = TMO_W'(1);
    ticks(2);
    pin_async_i = 1'b0; idle(6);
    check(done_cnt == d0 + 1, "R10 single done", done_cnt - d0, 1);
    check(last_res == 5, "R10/R2 busy start ignored", last_res, 5);
    idle(10);
    check(done_cnt == d0 + 1, "R10 no restart", done_cnt - d0, 1);
  endtask

  // R9: result holds, done lasts one cycle
  task automatic t_hold();
    logic signed [31:0] r0;
    int hi;
    r0 = result_o;
    hi = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done_o) hi++;
    end
    check(result_o == r0, "R9 result held", result_o, r0);
    check(hi == 0, "R9 no stray done", hi, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    check(done_o == 1'b0, "R1 done after reset", done_o, 0);
    check(result_o == 0, "R1 result after reset", result_o, 0);
    t_immediate(1'b1, 4, 10, "R3/R2 high pulse");
    t_hold();
    t_immediate(1'b0, 6, 10, "R2 low pulse");
    t_immediate(1'b1, 9, 10, "R8 width below timeout");
    t_wait_then_measure();
    t_wait_timeout();
    t_meas_timeout();
    t_zero_timeout();
    t_busy_start();
    finish_run();
  end
endmodule